// File: doc/BRIEF.md
# Network Interface Command and Acknowledge Register Unit

This block is the processor-facing register file of one network interface. The processor addresses it as a memory-mapped device on a 32-bit data bus. It can load the source and destination buffer pointers, the remote write address, the status buffer pointer and a configuration word. A write of one 32-bit operation word launches or steers a transfer. The unit decodes the function byte of that word into a one-cycle command strobe for the transfer engine that follows it. It latches the length, remote-operation and destination bytes for use by that engine.

The engine reports the end of a transfer through `ack_arrive`, with the outcome on `ack_ok`. Software polls a two-bit acknowledge register. The done bit drops when a transfer is launched and rises on arrival. The result bit is meaningful only while done is set. A function code the unit does not know sets a sticky error flag and raises no strobe. The processor can read that flag. Only reset clears it.

Top module: `netif_cmd_regs`

## Requirements
- R1: An access is taken only when `cpu_sel` is high, address bits 11:8 equal `PART_ID`, bits 7:4 equal `UNIT_ID` and bits 2:0 are zero. Bit 3 is ignored. A write that is not taken changes no register, and a read that is not taken returns zero.
- R2: Address bits 15:12 pick the register: 0 operation, 1 acknowledge, 2 configuration, 3 status pointer, 4 inbound buffer, 5 outbound buffer, 6 remote address, 7 state. Each pointer register reads back its last written value and holds it until rewritten.
- R3: The configuration word is replaced only as a whole 32-bit word, by a write to index 2. It drives `cfg_word`.
- R4: Writing the operation word raises exactly one `cmd_strobe` bit for the cycle after the write, chosen by bits 23:16. Code 0x01 gives bit 0 (launch with turn), 0x02 gives bit 1 (launch without turn), 0x03 gives bit 2 (close connection), 0x04 gives bit 3 (respond and turn), 0x05 gives bit 4 (respond and close), and 0x06 gives bit 5 (abort).
- R5: The length field (bits 31:24), remote-operation field (bits 15:8) and destination field (bits 7:0) are latched to `op_len`, `op_code` and `op_dst` only by a code 0x01 write. Reading index 0 returns the last such word.
- R6: A code other than 0x01 to 0x06 raises no strobe and sets state bit 0. That bit stays set until reset.
- R7: Reading index 1 returns bit 1 done and bit 0 result, with bits 31:2 zero. Codes 0x01, 0x02, 0x04 and 0x05 clear done. A pulse on `ack_arrive` sets done and loads `ack_ok` into the result bit.
- R8: When a launching write and `ack_arrive` fall in the same cycle, the launch wins and done reads 0 afterwards.
- R9: Codes 0x03 and 0x06 leave the acknowledge register unchanged.
- R10: After reset, all registers, the error flag, the acknowledge bits and the strobes are zero.
- R11: Writes to the acknowledge and state indices have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_sel | input | 1 | Processor access select |
| cpu_wr | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 16 | Access address |
| cpu_wdata | input | 32 | Write data |
| cpu_rdata | output | 32 | Read data (combinational) |
| ack_arrive | input | 1 | Engine reports acknowledge or final checksum |
| ack_ok | input | 1 | Outcome accompanying `ack_arrive` |
| cmd_strobe | output | 6 | One-cycle command strobes |
| op_len | output | 8 | Latched transfer length |
| op_code | output | 8 | Latched remote operation |
| op_dst | output | 8 | Latched destination node |
| cfg_word | output | 32 | Configuration word |
| status_ptr | output | 32 | Status buffer pointer |
| in_buf_ptr | output | 32 | Inbound buffer pointer |
| out_buf_ptr | output | 32 | Outbound buffer pointer |
| remote_addr | output | 32 | Remote write address |

## Verification
A launching operation write and an arriving acknowledge can land on the same clock edge. In that case the unit must clear done rather than set it, because the arrival belongs to the transfer being replaced. The bench first sets done with a prior arrival. It then drives a launch write and an `ack_arrive` pulse in one cycle, and reads the acknowledge register back, expecting zero. A later lone arrival must set done again.

// File: rtl/netif_cmd_regs.sv
module netif_cmd_regs #(
  parameter logic [3:0] PART_ID   = 4'h2,
  parameter logic [3:0] UNIT_ID   = 4'h1,
  parameter logic [7:0] F_LAUNCH  = 8'h01,
  parameter logic [7:0] F_NOTURN  = 8'h02,
  parameter logic [7:0] F_CLOSE   = 8'h03,
  parameter logic [7:0] F_REPLY   = 8'h04,
  parameter logic [7:0] F_REPLYCL = 8'h05,
  parameter logic [7:0] F_ABORT   = 8'h06
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cpu_sel,
  input  logic        cpu_wr,
  input  logic [15:0] cpu_addr,
  input  logic [31:0] cpu_wdata,
  output logic [31:0] cpu_rdata,
  input  logic        ack_arrive,
  input  logic        ack_ok,
  output logic [5:0]  cmd_strobe,
  output logic [7:0]  op_len,
  output logic [7:0]  op_code,
  output logic [7:0]  op_dst,
  output logic [31:0] cfg_word,
  output logic [31:0] status_ptr,
  output logic [31:0] in_buf_ptr,
  output logic [31:0] out_buf_ptr,
  output logic [31:0] remote_addr
);

  localparam int NSTB = 6;

  logic        hit;
  logic [3:0]  idx;
  logic [7:0]  func;
  logic        op_wr, launch, known;
  logic [NSTB-1:0] dec;
  logic [31:0] op_word;
  logic        ack_done, ack_res, err;

  assign hit  = cpu_sel && cpu_addr[11:8] == PART_ID &&
                cpu_addr[7:4] == UNIT_ID && cpu_addr[2:0] == 3'b000;
  assign idx  = cpu_addr[15:12];
  assign func = cpu_wdata[23:16];
  assign op_wr = hit && cpu_wr && idx == 4'd0;

  always_comb begin
    dec = '0;
    case (func)
      F_LAUNCH:  dec[0] = 1'b1;
      F_NOTURN:  dec[1] = 1'b1;
      F_CLOSE:   dec[2] = 1'b1;
      F_REPLY:   dec[3] = 1'b1;
      F_REPLYCL: dec[4] = 1'b1;
      F_ABORT:   dec[5] = 1'b1;
      default:   dec = '0;
    endcase
  end

  assign known  = |dec;
  assign launch = op_wr && (dec[0] || dec[1] || dec[3] || dec[4]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_strobe  <= '0;
      op_word     <= '0;
      cfg_word    <= '0;
      status_ptr  <= '0;
      in_buf_ptr  <= '0;
      out_buf_ptr <= '0;
      remote_addr <= '0;
      ack_done    <= 1'b0;
      ack_res     <= 1'b0;
      err         <= 1'b0;
    end else begin
      cmd_strobe <= op_wr ? dec : '0;
      if (op_wr && dec[0]) op_word <= cpu_wdata;
      if (op_wr && !known) err <= 1'b1;
      if (hit && cpu_wr) begin
        case (idx)
          4'd2: cfg_word    <= cpu_wdata;
          4'd3: status_ptr  <= cpu_wdata;
          4'd4: in_buf_ptr  <= cpu_wdata;
          4'd5: out_buf_ptr <= cpu_wdata;
          4'd6: remote_addr <= cpu_wdata;
          default: ;
        endcase
      end
      if (launch) begin
        ack_done <= 1'b0;
        ack_res  <= 1'b0;
      end else if (ack_arrive) begin
        ack_done <= 1'b1;
        ack_res  <= ack_ok;
      end
    end
  end

  assign op_len  = op_word[31:24];
  assign op_code = op_word[15:8];
  assign op_dst  = op_word[7:0];

  always_comb begin
    cpu_rdata = '0;
    if (hit && !cpu_wr) begin
      case (idx)
        4'd0: cpu_rdata = op_word;
        4'd1: cpu_rdata = {30'd0, ack_done, ack_res};
        4'd2: cpu_rdata = cfg_word;
        4'd3: cpu_rdata = status_ptr;
        4'd4: cpu_rdata = in_buf_ptr;
        4'd5: cpu_rdata = out_buf_ptr;
        4'd6: cpu_rdata = remote_addr;
        4'd7: cpu_rdata = {31'd0, err};
        default: cpu_rdata = '0;
      endcase
    end
  end

  assert_strobe_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cmd_strobe));
  assert_strobe_from_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_strobe != '0) |-> $past(op_wr));
  assert_strobe_one_cycle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_strobe != '0 && !op_wr) |=> cmd_strobe == '0);
  assert_fields_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(op_wr && func == F_LAUNCH) |=> $stable({op_len, op_code, op_dst}));
  assert_bad_func_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (op_wr && !known) |=> (cmd_strobe == '0 && err));
  assert_err_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);
  assert_ack_cleared_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (launch && !ack_arrive) |=> !ack_done);
  assert_ack_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_arrive && !op_wr) |=> (ack_done && ack_res == $past(ack_ok)));
  assert_launch_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (launch && ack_arrive) |=> !ack_done);
  assert_ack_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (op_wr && (func == F_CLOSE || func == F_ABORT) && !ack_arrive)
      |=> $stable({ack_done, ack_res}));
  assert_cfg_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(hit && cpu_wr && idx == 4'd2) |=> $stable(cfg_word));

endmodule

// File: tb/sim_netif_cmd_regs.sv
module sim_netif_cmd_regs;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cpu_sel = 1'b0, cpu_wr = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [31:0] cpu_wdata = '0;
  logic [31:0] cpu_rdata;
  logic ack_arrive = 1'b0, ack_ok = 1'b0;
  logic [5:0] cmd_strobe;
  logic [7:0] op_len, op_code, op_dst;
  logic [31:0] cfg_word, status_ptr, in_buf_ptr, out_buf_ptr, remote_addr;

  int total = 0;
  int bad = 0;
  logic [31:0] rd;

  always #5 clk = ~clk;

  netif_cmd_regs u0 (
    .clk(clk), .rst_n(rst_n), .cpu_sel(cpu_sel), .cpu_wr(cpu_wr),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .ack_arrive(ack_arrive), .ack_ok(ack_ok), .cmd_strobe(cmd_strobe),
    .op_len(op_len), .op_code(op_code), .op_dst(op_dst),
    .cfg_word(cfg_word), .status_ptr(status_ptr), .in_buf_ptr(in_buf_ptr),
    .out_buf_ptr(out_buf_ptr), .remote_addr(remote_addr)
  );

  // register index i at part 2, unit 1: {i, 4'h2, 4'h1, 4'h0}
  function automatic logic [15:0] ra(input logic [3:0] i);
    return {i, 12'h210};
  endfunction

  // {write addr, write data, read addr, expected read}
  localparam logic [111:0] VEC [13] = '{
    {16'h4210, 32'h0000_00A1, 16'h4210, 32'h0000_00A1, 16'h0}, // R2 in buf
    {16'h5210, 32'h0000_00B2, 16'h5210, 32'h0000_00B2, 16'h0}, // R2 out buf
    {16'h6210, 32'h0000_00C3, 16'h6210, 32'h0000_00C3, 16'h0}, // R2 remote
    {16'h3210, 32'h0000_00D4, 16'h3210, 32'h0000_00D4, 16'h0}, // R2 status
    {16'h2210, 32'hE5E5_0102, 16'h2210, 32'hE5E5_0102, 16'h0}, // R3 config
    {16'h4220, 32'hFFFF_FFFF, 16'h4210, 32'h0000_00A1, 16'h0}, // R1 wrong unit
    {16'h4310, 32'hFFFF_FFFF, 16'h4210, 32'h0000_00A1, 16'h0}, // R1 wrong part
    {16'h4214, 32'hFFFF_FFFF, 16'h4210, 32'h0000_00A1, 16'h0}, // R1 misaligned
    {16'h0000, 32'h0000_0000, 16'h4220, 32'h0000_0000, 16'h0}, // R1 foreign read
    {16'h4218, 32'h0000_1234, 16'h4210, 32'h0000_1234, 16'h0}, // R1 bit 3 ignored
    {16'h1210, 32'h0000_0003, 16'h1210, 32'h0000_0000, 16'h0}, // R11 ack
    {16'h7210, 32'hFFFF_FFFF, 16'h7210, 32'h0000_0000, 16'h0}, // R11 state
    {16'h2210, 32'h0000_0000, 16'h2210, 32'h0000_0000, 16'h0}  // R3 rewrite
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    cpu_sel = 1'b1; cpu_wr = 1'b1; cpu_addr = a; cpu_wdata = d;
    @(negedge clk);
    cpu_sel = 1'b0; cpu_wr = 1'b0;
  endtask

  task automatic rdreg(input logic [15:0] a, output logic [31:0] d);
    @(negedge clk);
    cpu_sel = 1'b1; cpu_wr = 1'b0; cpu_addr = a;
    #1 d = cpu_rdata;
    cpu_sel = 1'b0;
  endtask

  task automatic arrive(input logic ok);
    @(negedge clk);
    ack_arrive = 1'b1; ack_ok = ok;
    @(negedge clk);
    ack_arrive = 1'b0; ack_ok = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R10 reset state
    check("R10 strobe", {26'd0, cmd_strobe}, 32'd0);
    check("R10 cfg", cfg_word, 32'd0);
    rdreg(ra(4'd1), rd); check("R10 ack", rd, 32'd0);
    rdreg(ra(4'd7), rd); check("R10 state", rd, 32'd0);

    for (int i = 0; i < 13; i++) begin
      wr(VEC[i][111:96], VEC[i][95:64]);
      rdreg(VEC[i][63:48], rd);
      check("R1/R2/R3/R11 table", rd, VEC[i][47:16]);
    end
    check("R2 pointer port", in_buf_ptr, 32'h0000_1234);

    // R4 R5 launch
    wr(ra(4'd0), 32'h10_01_22_33);
    check("R4 launch strobe", {26'd0, cmd_strobe}, 32'h01);
    @(negedge clk);
    check("R4 strobe one cycle", {26'd0, cmd_strobe}, 32'h00);
    check("R5 fields", {8'd0, op_len, op_code, op_dst}, 32'h0010_2233);
    rdreg(ra(4'd0), rd); check("R5 op readback", rd, 32'h1001_2233);
    rdreg(ra(4'd1), rd); check("R7 done cleared", rd, 32'd0);
    arrive(1'b1);
    rdreg(ra(4'd1), rd); check("R7 ack ok", rd, 32'd3);

    // R9 close and abort keep ack, R5 fields kept
    wr(ra(4'd0), 32'hAA_03_BB_CC);
    check("R4 close strobe", {26'd0, cmd_strobe}, 32'h04);
    check("R5 fields kept", {8'd0, op_len, op_code, op_dst}, 32'h0010_2233);
    rdreg(ra(4'd1), rd); check("R9 ack after close", rd, 32'd3);
    wr(ra(4'd0), 32'h00_06_00_00);
    check("R4 abort strobe", {26'd0, cmd_strobe}, 32'h20);
    rdreg(ra(4'd1), rd); check("R9 ack after abort", rd, 32'd3);

    // respond paths
    wr(ra(4'd0), 32'h00_04_00_00);
    check("R4 respond strobe", {26'd0, cmd_strobe}, 32'h08);
    rdreg(ra(4'd1), rd); check("R7 respond clears", rd, 32'd0);
    arrive(1'b0);
    rdreg(ra(4'd1), rd); check("R7 ack fail", rd, 32'd2);
    wr(ra(4'd0), 32'h00_05_00_00);
    check("R4 respond-close strobe", {26'd0, cmd_strobe}, 32'h10);
    wr(ra(4'd0), 32'h55_02_66_77);
    check("R4 noturn strobe", {26'd0, cmd_strobe}, 32'h02);
    check("R5 noturn no latch", {8'd0, op_len, op_code, op_dst}, 32'h0010_2233);

    // R6 unknown code
    wr(ra(4'd0), 32'h00_7E_00_00);
    check("R6 no strobe", {26'd0, cmd_strobe}, 32'h00);
    rdreg(ra(4'd7), rd); check("R6 err set", rd, 32'd1);
    wr(ra(4'd0), 32'h04_01_05_06);
    check("R6 later op works", {26'd0, cmd_strobe}, 32'h01);
    check("R5 new fields", {8'd0, op_len, op_code, op_dst}, 32'h0004_0506);
    rdreg(ra(4'd7), rd); check("R6 err sticky", rd, 32'd1);

    // R8 collision
    arrive(1'b1);
    rdreg(ra(4'd1), rd); check("R8 pre", rd, 32'd3);
    @(negedge clk);
    cpu_sel = 1'b1; cpu_wr = 1'b1; cpu_addr = ra(4'd0); cpu_wdata = 32'h01_01_02_03;
    ack_arrive = 1'b1; ack_ok = 1'b1;
    @(negedge clk);
    cpu_sel = 1'b0; cpu_wr = 1'b0; ack_arrive = 1'b0; ack_ok = 1'b0;
    rdreg(ra(4'd1), rd); check("R8 launch wins", rd, 32'd0);
    arrive(1'b1);
    rdreg(ra(4'd1), rd); check("R8 later arrival", rd, 32'd3);

    // R10 reset mid-run
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk) rst_n = 1'b1;
    rdreg(ra(4'd7), rd); check("R10 err cleared", rd, 32'd0);
    rdreg(ra(4'd1), rd); check("R10 ack cleared", rd, 32'd0);
    check("R10 pointers", in_buf_ptr | status_ptr | remote_addr | out_buf_ptr, 32'd0);
    check("R10 fields", {8'd0, op_len, op_code, op_dst}, 32'd0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule